// File: doc/BRIEF.md
# Multi-channel vertical toggle pattern generator

This block drives a bank of vertical-clock lines for an image-sensor timing generator. A pixel counter restarts on every falling edge of the horizontal sync input. Each line of the bank starts a pattern at a shared start offset, at the level given by its own polarity bit. It then inverts at up to four programmable positions. These positions are measured from the start of the pattern, not from the start of the line. The pattern has a shared length and can repeat a programmable number of times. At each repeat every channel returns to its start polarity.

A channel can be marked as a sensor-gate pulse. In that mode only one pair of its toggles is used, and a select bit chooses the lower pair or the upper pair. Software writes a staging copy of every setting through a narrow write port. The staging copy moves into the working copy only at a horizontal sync falling edge, so a line in progress never changes shape.

Top module: `vpat_gen`

## Requirements
- R1: After reset every bit of `vout_o` is 0. It stays 0 until the first falling edge of `hsync_i`, whatever settings are written.
- R2: The cycle in which `hsync_i` is first sampled low is pixel 0. The level for pixel p appears on `vout_o` after p+2 rising edges, counted from and including that edge. Before pixel `offset`, a channel outputs its polarity bit.
- R3: Within a pattern, a channel's level at position q (pixel minus offset, modulo length) is its polarity XOR the parity of the number of distinct enabled toggle values that are less than or equal to q.
- R4: A toggle value of 0 or 8191 (all ones) is disabled and never causes a transition.
- R5: Two or more enabled toggles of one channel that hold the same value invert the output only once.
- R6: The position counts 0 to length-1 and then wraps to 0, and the level returns to the polarity. With repeat field n, the pattern plays n+1 times. After that, the channel outputs its polarity until the next line.
- R7: Mode bit 1 set selects gate-pulse mode. In that mode, mode bit 2 = 0 enables only toggles 0 and 1, and mode bit 2 = 1 enables only toggles 2 and 3.
- R8: Writes go to staging registers. They take effect only at the next `hsync_i` falling edge, so a write made during a line leaves that line unchanged.
- R9: Field codes for `cfg_fld_i`:
  - 0 to 3 write toggle 0 to 3 of channel `cfg_ch_i`.
  - 4 writes that channel's mode bits: bit 0 polarity, bit 1 gate mode, bit 2 pair select.
  - 5 writes the shared offset, 6 writes the shared length, and 7 writes the repeat count from the low bits of the data.
  - A length of 0 means 8192.
- R10: A falling edge of `hsync_i` in the middle of a pattern restarts the line at pixel 0 and restarts the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync; its falling edge starts a line |
| cfg_we_i | input | 1 | Write strobe for the staging registers |
| cfg_ch_i | input | CH_W | Channel index for per-channel fields |
| cfg_fld_i | input | 3 | Field code (see R9) |
| cfg_data_i | input | POS_W | Write data |
| vout_o | output | NUM_CH | Channel output levels |

## Verification
Every pixel of every line is compared, across all channels at once, with a model computed in the bench from the settings.

Directed lines each isolate one effect:
- A plain two-toggle and four-toggle pattern behind a nonzero offset separates offset handling from toggle handling.
- Toggle values of 0 and 8191 show whether the disable rule holds.
- Coincident toggles show whether the output double-inverts.
- A short repeating pattern shows wrap and the end of the repeats.
- The two gate-pair selects show which toggles survive.

Further lines check that a mid-line write is held back and that a sync edge mid-pattern restarts it. Random lines with varied offsets, lengths, repeats, polarities and pair selects then cover the combinations together.

// File: rtl/vpat_pkg.sv
package vpat_pkg;
  typedef enum logic [2:0] {
    FLD_TOG0 = 3'd0,
    FLD_TOG1 = 3'd1,
    FLD_TOG2 = 3'd2,
    FLD_TOG3 = 3'd3,
    FLD_MODE = 3'd4,
    FLD_OFFS = 3'd5,
    FLD_LEN  = 3'd6,
    FLD_REPS = 3'd7
  } cfg_fld_e;

  typedef struct packed {
    logic pair_hi;  // bit 2
    logic gate;     // bit 1
    logic pol;      // bit 0
  } ch_mode_t;

  localparam int NUM_TOG = 4;
endpackage

// File: rtl/vpat_cfg.sv
module vpat_cfg
  import vpat_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int POS_W  = 13,
  parameter int REP_W  = 8,
  parameter int CH_W   = 5
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        we_i,
  input  logic [CH_W-1:0]                             ch_i,
  input  logic [2:0]                                  fld_i,
  input  logic [POS_W-1:0]                            data_i,
  input  logic                                        load_i,
  output logic [NUM_CH-1:0][NUM_TOG-1:0][POS_W-1:0]   tog_o,
  output ch_mode_t [NUM_CH-1:0]                       mode_o,
  output logic [POS_W-1:0]                            offs_o,
  output logic [POS_W-1:0]                            len_o,
  output logic [REP_W-1:0]                            reps_o
);
  logic [NUM_CH-1:0][NUM_TOG-1:0][POS_W-1:0] stg_tog;
  ch_mode_t [NUM_CH-1:0]                     stg_mode;
  logic [POS_W-1:0]                          stg_offs, stg_len;
  logic [REP_W-1:0]                          stg_reps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_tog  <= '0;
      stg_mode <= '0;
      stg_offs <= '0;
      stg_len  <= '0;
      stg_reps <= '0;
    end else if (we_i) begin
      case (cfg_fld_e'(fld_i))
        FLD_OFFS: stg_offs <= data_i;
        FLD_LEN:  stg_len  <= data_i;
        FLD_REPS: stg_reps <= data_i[REP_W-1:0];
        FLD_MODE: begin
          if (int'(ch_i) < NUM_CH) stg_mode[ch_i] <= ch_mode_t'(data_i[2:0]);
        end
        default: begin
          if (int'(ch_i) < NUM_CH) stg_tog[ch_i][fld_i[1:0]] <= data_i;
        end
      endcase
    end
  end

  // working copy follows staging only at line start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_o  <= '0;
      mode_o <= '0;
      offs_o <= '0;
      len_o  <= '0;
      reps_o <= '0;
    end else if (load_i) begin
      tog_o  <= stg_tog;
      mode_o <= stg_mode;
      offs_o <= stg_offs;
      len_o  <= stg_len;
      reps_o <= stg_reps;
    end
  end
endmodule

// File: rtl/vpat_seq.sv
module vpat_seq #(
  parameter int POS_W = 13,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic [POS_W-1:0] offs_i,
  input  logic [POS_W-1:0] len_i,
  input  logic [REP_W-1:0] reps_i,
  output logic             fall_o,
  output logic [POS_W-1:0] pix_o,
  output logic             run_o,
  output logic [POS_W-1:0] pos_o,
  output logic [REP_W-1:0] rep_o,
  output logic             cur_run_o,
  output logic [POS_W-1:0] cur_pos_o
);
  logic             hs_q, arm_q;
  logic [POS_W-1:0] last_pos;
  logic [REP_W-1:0] cur_rep;

  assign fall_o    = hs_q & ~hsync_i;
  assign last_pos  = len_i - 1'b1;  // length 0 wraps to full range
  // pattern begins in the cycle whose pixel equals the offset
  assign cur_run_o = run_o | (arm_q & (pix_o == offs_i));
  assign cur_pos_o = run_o ? pos_o : '0;
  assign cur_rep   = run_o ? rep_o : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      arm_q <= 1'b0;
      pix_o <= '0;
      run_o <= 1'b0;
      pos_o <= '0;
      rep_o <= '0;
    end else begin
      hs_q <= hsync_i;
      if (fall_o) begin
        pix_o <= '0;
        arm_q <= 1'b1;
        run_o <= 1'b0;
        pos_o <= '0;
        rep_o <= '0;
      end else begin
        if (pix_o != '1) pix_o <= pix_o + 1'b1;
        if (cur_run_o) begin
          arm_q <= 1'b0;
          if (cur_pos_o == last_pos) begin
            pos_o <= '0;
            if (cur_rep == reps_i) begin
              run_o <= 1'b0;
            end else begin
              run_o <= 1'b1;
              rep_o <= cur_rep + 1'b1;
            end
          end else begin
            run_o <= 1'b1;
            pos_o <= cur_pos_o + 1'b1;
            rep_o <= cur_rep;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vpat_chan.sv
module vpat_chan
  import vpat_pkg::*;
#(
  parameter int POS_W = 13
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_TOG-1:0][POS_W-1:0]  tog_i,
  input  ch_mode_t                       mode_i,
  input  logic                           run_i,
  input  logic [POS_W-1:0]               pos_i,
  output logic                           vout_o
);
  logic [NUM_TOG-1:0] en, hit;
  logic               lvl;

  always_comb begin
    for (int k = 0; k < NUM_TOG; k++) begin
      en[k] = (tog_i[k] != '0) && (tog_i[k] != '1) &&
              (!mode_i.gate || (mode_i.pair_hi ? (k >= 2) : (k < 2)));
    end
    for (int k = 0; k < NUM_TOG; k++) begin
      hit[k] = en[k] && (tog_i[k] <= pos_i);
      // coincident toggles count once
      for (int j = 0; j < k; j++) begin
        if (en[j] && (tog_i[j] == tog_i[k])) hit[k] = 1'b0;
      end
    end
    lvl = mode_i.pol ^ (^hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vout_o <= 1'b0;
    else         vout_o <= run_i ? lvl : mode_i.pol;
  end
endmodule

// File: rtl/vpat_gen.sv
module vpat_gen
  import vpat_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int POS_W  = 13,
  parameter int REP_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [2:0]        cfg_fld_i,
  input  logic [POS_W-1:0]  cfg_data_i,
  output logic [NUM_CH-1:0] vout_o
);
  logic [NUM_CH-1:0][NUM_TOG-1:0][POS_W-1:0] act_tog;
  ch_mode_t [NUM_CH-1:0]                     act_mode;
  logic [NUM_CH-1:0]                         act_pol;
  logic [POS_W-1:0]                          act_offs, act_len, pix_q, pos_q, cur_pos;
  logic [REP_W-1:0]                          act_reps, rep_q;
  logic                                      fall, run_q, cur_run;

  vpat_cfg #(.NUM_CH(NUM_CH), .POS_W(POS_W), .REP_W(REP_W), .CH_W(CH_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .ch_i   (cfg_ch_i),
    .fld_i  (cfg_fld_i),
    .data_i (cfg_data_i),
    .load_i (fall),
    .tog_o  (act_tog),
    .mode_o (act_mode),
    .offs_o (act_offs),
    .len_o  (act_len),
    .reps_o (act_reps)
  );

  vpat_seq #(.POS_W(POS_W), .REP_W(REP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hsync_i   (hsync_i),
    .offs_i    (act_offs),
    .len_i     (act_len),
    .reps_i    (act_reps),
    .fall_o    (fall),
    .pix_o     (pix_q),
    .run_o     (run_q),
    .pos_o     (pos_q),
    .rep_o     (rep_q),
    .cur_run_o (cur_run),
    .cur_pos_o (cur_pos)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign act_pol[c] = act_mode[c].pol;
    vpat_chan #(.POS_W(POS_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tog_i  (act_tog[c]),
      .mode_i (act_mode[c]),
      .run_i  (cur_run),
      .pos_i  (cur_pos),
      .vout_o (vout_o[c])
    );
  end
endmodule

// File: rtl/vpat_gen_chk.sv
module vpat_gen_chk #(
  parameter int NUM_CH = 24,
  parameter int POS_W  = 13,
  parameter int REP_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fall,
  input logic [POS_W-1:0]  pix_q,
  input logic              run_q,
  input logic              cur_run,
  input logic [POS_W-1:0]  pos_q,
  input logic [REP_W-1:0]  rep_q,
  input logic [POS_W-1:0]  act_offs,
  input logic [POS_W-1:0]  act_len,
  input logic [REP_W-1:0]  act_reps,
  input logic [NUM_CH-1:0] act_pol,
  input logic [NUM_CH-1:0] vout_o
);
  p_line_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> (pix_q == '0) && !run_q);

  p_pix_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && (pix_q != '1)) |=> (pix_q == $past(pix_q) + 1'b1));

  p_idle_pol_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_run |=> (vout_o == $past(act_pol)));

  p_pos_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (act_len != '0)) |-> (pos_q < act_len));

  p_rep_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (rep_q <= act_reps));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(act_offs) && $stable(act_len) && $stable(act_reps) && $stable(act_pol));
endmodule

bind vpat_gen vpat_gen_chk #(.NUM_CH(NUM_CH), .POS_W(POS_W), .REP_W(REP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fall     (fall),
  .pix_q    (pix_q),
  .run_q    (run_q),
  .cur_run  (cur_run),
  .pos_q    (pos_q),
  .rep_q    (rep_q),
  .act_offs (act_offs),
  .act_len  (act_len),
  .act_reps (act_reps),
  .act_pol  (act_pol),
  .vout_o   (vout_o)
);

// File: tb/vpat_gen_tb_top.sv
`timescale 1ns/1ps
module vpat_gen_tb_top;
  localparam int NCH  = 24;
  localparam int PW   = 13;
  localparam int RW   = 8;
  localparam int CW   = 5;
  localparam int PMAX = 8191;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync = 1'b1;
  logic          we = 1'b0;
  logic [CW-1:0] ch = '0;
  logic [2:0]    fld = '0;
  logic [PW-1:0] data = '0;
  logic [NCH-1:0] vout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // staging and working mirrors
  int s_tog [NCH][4];
  int s_mode[NCH];
  int s_offs, s_len, s_reps;
  int a_tog [NCH][4];
  int a_mode[NCH];
  int a_offs, a_len, a_reps;

  // pending mid-line write
  int pw_ch, pw_fld, pw_data;

  always #10 clk = ~clk;

  vpat_gen #(.NUM_CH(NCH), .POS_W(PW), .REP_W(RW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .hsync_i    (hsync),
    .cfg_we_i   (we),
    .cfg_ch_i   (ch),
    .cfg_fld_i  (fld),
    .cfg_data_i (data),
    .vout_o     (vout)
  );

  function automatic void stage(int c, int f, int d);
    case (f)
      4: s_mode[c] = d & 7;
      5: s_offs = d;
      6: s_len = d;
      7: s_reps = d & 255;
      default: s_tog[c][f] = d;
    endcase
  endfunction

  function automatic bit tog_en(int c, int k);
    int t = a_tog[c][k];
    bit g = a_mode[c][1];
    bit hi = a_mode[c][2];
    if (t == 0 || t == PMAX) return 0;
    if (g && (hi ? (k < 2) : (k >= 2))) return 0;
    return 1;
  endfunction

  function automatic bit exp_lvl(int c, int p);
    int q, L, pos;
    bit pol = a_mode[c][0];
    bit par = 0;
    if (p < a_offs) return pol;
    q = p - a_offs;
    L = (a_len == 0) ? 8192 : a_len;
    if (q / L > a_reps) return pol;
    pos = q % L;
    for (int k = 0; k < 4; k++) begin
      bit dup = 0;
      if (!tog_en(c, k)) continue;
      for (int j = 0; j < k; j++)
        if (tog_en(c, j) && a_tog[c][j] == a_tog[c][k]) dup = 1;
      if (!dup && a_tog[c][k] <= pos) par = ~par;
    end
    return pol ^ par;
  endfunction

  task automatic wr(int c, int f, int d);
    @(negedge clk);
    we = 1'b1; ch = CW'(c); fld = 3'(f); data = PW'(d);
    stage(c, f, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_vec(string tag, int p, logic [NCH-1:0] e);
    checks++;
    if (vout !== e) begin
      errors++;
      $display("FAIL %s pixel %0d act %h exp %h", tag, p, vout, e);
    end
  endtask

  // one line: fall of hsync, compare every pixel; optional write at pixel wr_at
  task automatic run_line(string tag, int n, int wr_at);
    logic [NCH-1:0] e;
    @(negedge clk);
    hsync = 1'b0;
    @(posedge clk);
    a_tog = s_tog; a_mode = s_mode;
    a_offs = s_offs; a_len = s_len; a_reps = s_reps;
    for (int p = 0; p < n; p++) begin
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) e[c] = exp_lvl(c, p);
      chk_vec(tag, p, e);
      if (p == wr_at) begin
        we = 1'b1; ch = CW'(pw_ch); fld = 3'(pw_fld); data = PW'(pw_data);
        stage(pw_ch, pw_fld, pw_data);
      end else if (p == wr_at + 1) begin
        we = 1'b0;
      end
    end
    we = 1'b0;
    hsync = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_vec("R1 reset", i, '0);
    end
    wr(0, 4, 1);
    wr(1, 4, 1);
    wr(0, 6, 30);
    repeat (3) @(negedge clk);
    chk_vec("R8 R1 no load before sync", 0, '0);
  endtask

  task automatic t_basic();
    wr(0, 0, 5);  wr(0, 1, 10);
    wr(1, 0, 3);  wr(1, 1, 7); wr(1, 2, 12); wr(1, 3, 20);
    wr(0, 5, 4);  wr(0, 6, 30); wr(0, 7, 0);
    run_line("R2 R3 basic offset", 50, -1);
    // R9: length 0 is 8192, two plays still fit past end of line
    wr(0, 6, 0); wr(0, 7, 1);
    run_line("R9 length zero", 40, -1);
  endtask

  task automatic t_unused();
    wr(2, 4, 1);
    wr(2, 0, 0); wr(2, 1, PMAX); wr(2, 2, 6); wr(2, 3, 0);
    wr(0, 5, 2); wr(0, 6, 20); wr(0, 7, 0);
    run_line("R4 disabled toggles", 30, -1);
  endtask

  task automatic t_equal();
    wr(3, 0, 6); wr(3, 1, 6); wr(3, 2, 9); wr(3, 3, 9);
    wr(4, 0, 6); wr(4, 1, 6); wr(4, 2, 6); wr(4, 3, 11);
    wr(4, 4, 0);
    run_line("R5 equal toggles", 30, -1);
  endtask

  task automatic t_repeat();
    wr(0, 5, 3); wr(0, 6, 8); wr(0, 7, 2);
    run_line("R6 repeat wrap", 45, -1);
  endtask

  task automatic t_gate();
    wr(5, 0, 2); wr(5, 1, 4); wr(5, 2, 5); wr(5, 3, 7); wr(5, 4, 2);
    wr(6, 0, 2); wr(6, 1, 4); wr(6, 2, 5); wr(6, 3, 7); wr(6, 4, 7);
    wr(0, 5, 1); wr(0, 6, 10); wr(0, 7, 1);
    run_line("R7 gate pair", 30, -1);
  endtask

  task automatic t_shadow();
    pw_ch = 0; pw_fld = 5; pw_data = 9;
    run_line("R8 mid-line write held", 30, 3);
    pw_ch = 1; pw_fld = 1; pw_data = 2;
    run_line("R8 new offset applied", 30, 5);
    run_line("R8 new toggle applied", 30, -1);
  endtask

  task automatic t_restart();
    wr(0, 5, 0); wr(0, 6, 40); wr(0, 7, 0);
    run_line("R10 cut short", 12, -1);
    run_line("R10 restart", 45, -1);
  endtask

  task automatic t_random();
    for (int l = 0; l < 6; l++) begin
      int len = $urandom_range(40, 1);
      wr(0, 5, $urandom_range(30, 0));
      wr(0, 6, len);
      wr(0, 7, $urandom_range(3, 0));
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < 4; k++) wr(c, k, $urandom_range(len + 2, 0));
        wr(c, 4, $urandom_range(7, 0));
      end
      run_line("R3 R7 random", 200, -1);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      s_mode[c] = 0;
      for (int k = 0; k < 4; k++) s_tog[c][k] = 0;
    end
    s_offs = 0; s_len = 0; s_reps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_unused();
    t_equal();
    t_repeat();
    t_gate();
    t_shadow();
    t_restart();
    t_random();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule